// File: doc/BRIEF.md
# Status Register Write Guard

This block holds the small status register of a serial non-volatile memory. It also decides whether a status write or an array write may go ahead. The serial front end sits upstream. It decodes each frame's instruction and hands over one command per frame as a single-cycle pulse, together with the target address and the status data byte. It also flags whether the frame ended on a whole-byte boundary. The write timer sits downstream. It receives the commit strobes and reports back through a busy flag.

Writes are gated in three ways:
- A write-enable latch must be armed before any write.
- Two block-protect bits fence off the upper quarter, the upper half or the whole array from array writes.
- A protect-enable bit, when set, lets the active-low hardware protect pin veto status writes. While that bit is clear, the pin has no effect. This means a board with the pin strapped low can still program the status register.

Nothing commits until chip select returns high. A protect pin pulse anywhere inside the frame cancels a pending status write. Once a write has committed and the timer is running, the pin can no longer undo it.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset, `status` reads 0x00 and neither `sr_commit` nor `arr_commit` is high.
- R2: `cmd_op` encodes 0 = enable writes, 1 = disable writes, 2 = status write, 3 = array write. An enable-writes frame sets the latch shown at `status` bit 1. A disable-writes frame clears it. Both take effect when chip select rises.
- R3: A status or array write in a frame where the latch is clear produces no strobe and leaves `status` unchanged.
- R4: An accepted status write raises `sr_commit` for one cycle, starting on the clock edge after chip select rises. It copies `cmd_data` bit 7 to the protect-enable bit (`status` bit 7) and `cmd_data` bits 3:2 to the block-protect bits (`status` bits 3:2). It clears the latch. `status` bits 6:4 always read 0.
- R5: While `status` bit 7 is 0, `wp_n` has no effect on status writes.
- R6: While `status` bit 7 is 1, a status write is dropped if `wp_n` is low at any sampled cycle of its frame, including the cycle in which chip select rises. When dropped, there is no strobe and `status`, including the latch, is unchanged.
- R7: Once a status write has committed, later `wp_n` activity cannot alter the committed value.
- R8: Block-protect value 0 locks nothing, 1 locks the top quarter of the address space, 2 locks the top half, and 3 locks everything. An array write to an unlocked address raises `arr_commit` for one cycle, shows the address on `arr_addr` and clears the latch. A write to a locked address does nothing and keeps the latch.
- R9: A frame whose `byte_aligned` is low in the cycle chip select rises has no effect of any kind.
- R10: `status` bit 0 follows `busy`. While `busy` is high, commands are not accepted, and a frame that ends while busy is high commits nothing.
- R11: Only the first command pulse of a frame counts; later pulses in the same frame are ignored.
- R12: `wp_n` never blocks array writes, whatever the value of the protect-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| busy | input | 1 | Write timer running |
| cmd_valid | input | 1 | One-cycle pulse: decoded command available |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Array byte address of an array write |
| cmd_data | input | 8 | Data byte of a status write |
| byte_aligned | input | 1 | Frame ended on a whole-byte boundary, read in the chip select rising cycle |
| status | output | 8 | {protect-enable, 000, block-protect[1:0], write-enable latch, busy} |
| sr_commit | output | 1 | One-cycle strobe: status write committed |
| arr_commit | output | 1 | One-cycle strobe: array write permitted and started |
| arr_addr | output | ADDR_W | Address of the last permitted array write |

## Verification
The properties assume the following about the inputs:
- `cs_n`, `wp_n` and `busy` are synchronous to `clk`.
- `busy` does not change in the cycle in which chip select rises for a frame whose outcome is being checked.
- `busy` is driven only by the timer, so it never rises during an idle stretch the bench treats as settled.

The bench changes every input half a period after a rising edge. It sends exactly one command pulse per frame, except in the scenario that deliberately sends two. It raises and lowers `busy` only between frames, so each frame's outcome depends on a single, known value of the busy flag.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [1:0] {
    OP_WREN  = 2'd0,
    OP_WRDI  = 2'd1,
    OP_WRSR  = 2'd2,
    OP_WRITE = 2'd3
  } wp_op_e;

  localparam int SR_W      = 8;
  localparam int SR_BUSY   = 0;
  localparam int SR_WEL    = 1;
  localparam int SR_BP_LSB = 2;
  localparam int SR_WPEN   = 7;

  // bits of the stored status register that a status write may change
  localparam logic [SR_W-1:0] SR_WR_MASK = 8'h8C;

endpackage

// File: rtl/wprot_rst_sync.sv
module wprot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/wprot_frame.sv
module wprot_frame
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              busy,
  input  logic              wp_guard,
  input  logic              cmd_valid,
  input  wp_op_e            cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SR_W-1:0]   cmd_data,
  output logic              frame_end,
  output logic              pend_valid,
  output wp_op_e            pend_op,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [SR_W-1:0]   pend_data,
  output logic              wp_hit
);

  logic              cs_q;
  logic              have_q, have_d;
  wp_op_e            op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SR_W-1:0]   data_q, data_d;
  logic              hit_q, hit_d;
  logic              frame_start;
  logic              in_frame;
  logic              take;

  assign in_frame    = ~cs_n;
  assign frame_start = cs_q & ~cs_n;
  assign frame_end   = ~cs_q & cs_n;
  assign take        = in_frame & cmd_valid & ~busy & (frame_start | ~have_q);

  always_comb begin
    have_d = have_q;
    op_d   = op_q;
    addr_d = addr_q;
    data_d = data_q;
    hit_d  = hit_q;
    if (frame_start) begin
      have_d = take;
      hit_d  = wp_guard;
    end else if (in_frame) begin
      have_d = have_q | take;
      hit_d  = hit_q | wp_guard;
    end else begin
      have_d = 1'b0;
      hit_d  = 1'b0;
    end
    if (take) begin
      op_d   = cmd_op;
      addr_d = cmd_addr;
      data_d = cmd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      have_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      have_q <= have_d;
      hit_q  <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_WREN;
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign pend_valid = have_q;
  assign pend_op    = op_q;
  assign pend_addr  = addr_q;
  assign pend_data  = data_q;
  assign wp_hit     = hit_q | wp_guard;

endmodule

// File: rtl/wprot_range.sv
module wprot_range #(
  parameter int ADDR_W = 13
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);

  localparam int unsigned SPAN    = 32'd1 << ADDR_W;
  localparam int unsigned HALF_LO = SPAN / 2;
  localparam int unsigned QTR_LO  = (SPAN / 4) * 3;

  logic [31:0] addr_ext;
  logic        in_half;
  logic        in_qtr;

  generate
    if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_width
      initial $error("wprot_range: ADDR_W out of range");
    end
  endgenerate

  assign addr_ext = 32'(addr);
  assign in_half  = addr_ext >= HALF_LO;
  assign in_qtr   = addr_ext >= QTR_LO;

  always_comb begin
    unique case (bp)
      2'd0:    locked = 1'b0;
      2'd1:    locked = in_qtr;
      2'd2:    locked = in_half;
      default: locked = 1'b1;
    endcase
  end

endmodule

// File: rtl/wprot_wel.sv
module wprot_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  output logic wel
);

  logic wel_q, wel_d;

  always_comb begin
    wel_d = wel_q;
    if (clr_en)      wel_d = 1'b0;
    else if (set_en) wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end

  assign wel = wel_q;

endmodule

// File: rtl/wprot_sreg.sv
module wprot_sreg
  import wprot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SR_W-1:0] wr_data,
  output logic [SR_W-1:0] sreg,
  output logic [1:0]      bp,
  output logic            wpen
);

  logic [SR_W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = wr_data & SR_WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg_q <= '0;
    else if (wr_en) sreg_q <= sreg_d;
  end

  assign sreg = sreg_q;
  assign bp   = sreg_q[SR_BP_LSB +: 2];
  assign wpen = sreg_q[SR_WPEN];

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              byte_aligned,
  output logic [7:0]        status,
  output logic              sr_commit,
  output logic              arr_commit,
  output logic [ADDR_W-1:0] arr_addr
);

  logic              rst_i;
  logic              wel;
  logic [1:0]        bp;
  logic              wpen;
  logic [SR_W-1:0]   sreg;
  logic              wp_guard;
  logic              frame_end;
  logic              pend_valid;
  wp_op_e            pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [SR_W-1:0]   pend_data;
  logic              wp_hit;
  logic              locked;
  logic              close_ok;
  logic              go_wren, go_wrdi, go_sr, go_arr;
  logic              sr_commit_q, arr_commit_q;
  logic [ADDR_W-1:0] arr_addr_q;

  wprot_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  assign wp_guard = ~wp_n & wpen;

  wprot_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_i),
    .cs_n       (cs_n),
    .busy       (busy),
    .wp_guard   (wp_guard),
    .cmd_valid  (cmd_valid),
    .cmd_op     (wp_op_e'(cmd_op)),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .frame_end  (frame_end),
    .pend_valid (pend_valid),
    .pend_op    (pend_op),
    .pend_addr  (pend_addr),
    .pend_data  (pend_data),
    .wp_hit     (wp_hit)
  );

  wprot_range #(.ADDR_W(ADDR_W)) u_range (
    .bp     (bp),
    .addr   (pend_addr),
    .locked (locked)
  );

  assign close_ok = frame_end & pend_valid & byte_aligned & ~busy;
  assign go_wren  = close_ok & (pend_op == OP_WREN);
  assign go_wrdi  = close_ok & (pend_op == OP_WRDI);
  assign go_sr    = close_ok & (pend_op == OP_WRSR) & wel & ~wp_hit;
  assign go_arr   = close_ok & (pend_op == OP_WRITE) & wel & ~locked;

  wprot_wel u_wel (
    .clk    (clk),
    .rst_n  (rst_i),
    .set_en (go_wren),
    .clr_en (go_wrdi | go_sr | go_arr),
    .wel    (wel)
  );

  wprot_sreg u_sreg (
    .clk     (clk),
    .rst_n   (rst_i),
    .wr_en   (go_sr),
    .wr_data (pend_data),
    .sreg    (sreg),
    .bp      (bp),
    .wpen    (wpen)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sr_commit_q  <= 1'b0;
      arr_commit_q <= 1'b0;
    end else begin
      sr_commit_q  <= go_sr;
      arr_commit_q <= go_arr;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      arr_addr_q <= '0;
    else if (go_arr) arr_addr_q <= pend_addr;
  end

  always_comb begin
    status          = sreg;
    status[SR_WEL]  = wel;
    status[SR_BUSY] = busy;
  end

  assign sr_commit  = sr_commit_q;
  assign arr_commit = arr_commit_q;
  assign arr_addr   = arr_addr_q;

endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic [7:0]        status,
  input logic              sr_commit,
  input logic              arr_commit,
  input logic [ADDR_W-1:0] arr_addr
);

  localparam int unsigned QUARTER = 32'd1 << (ADDR_W - 2);

  logic [31:0] quarter_idx;
  logic [2:0]  free_quarters;
  logic        arr_ok;

  assign quarter_idx = 32'(arr_addr) / QUARTER;

  always_comb begin
    case (status[3:2])
      2'd0:    free_quarters = 3'd4;
      2'd1:    free_quarters = 3'd3;
      2'd2:    free_quarters = 3'd2;
      default: free_quarters = 3'd0;
    endcase
  end

  assign arr_ok = quarter_idx < 32'(free_quarters);

  a_r4_status_moves_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:2] != $past(status[7:2])) |-> sr_commit);

  a_r4_reserved_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_commit, arr_commit}));

  a_r3_latch_required: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_commit || arr_commit) |-> $past(status[1]));

  a_r8_latch_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_commit || arr_commit) |-> !status[1]);

  a_r6_pin_veto: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit |-> $past(wp_n || !status[7]));

  a_r10_no_commit_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_commit || arr_commit) |-> $past(!status[0]));

  a_r10_no_arm_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(!status[0]));

  a_r8_unlocked_only: assert property (@(posedge clk) disable iff (!rst_n)
    arr_commit |-> arr_ok);

endmodule

bind wprot_ctrl wprot_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_n       (wp_n),
  .status     (status),
  .sr_commit  (sr_commit),
  .arr_commit (arr_commit),
  .arr_addr   (arr_addr)
);

// File: tb/wprot_ctrl_test.sv
`timescale 1ns/1ps
module wprot_ctrl_test;

  localparam int AW = 13;
  localparam logic [1:0] C_WREN = 2'd0, C_WRDI = 2'd1, C_WRSR = 2'd2, C_WRITE = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, wp_n, busy, cmd_valid, byte_aligned;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic [7:0]    status;
  logic          sr_commit, arr_commit;
  logic [AW-1:0] arr_addr;

  int n_checks = 0;
  int n_fail   = 0;
  logic          seen_sr, seen_arr;
  logic [AW-1:0] seen_addr;

  always #2.5 clk = ~clk;

  wprot_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .byte_aligned(byte_aligned), .status(status),
    .sr_commit(sr_commit), .arr_commit(arr_commit), .arr_addr(arr_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [1:0] op, input logic [AW-1:0] addr,
                       input logic [7:0] data, input logic aligned, input logic glitch);
    logic keep;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) begin cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data; end
    @(negedge clk) cmd_valid = 1'b0;
    if (glitch) begin
      keep = wp_n;
      wp_n = 1'b0;
      @(negedge clk) wp_n = keep;
    end
    @(negedge clk) begin cs_n = 1'b1; byte_aligned = aligned; end
    @(negedge clk) begin
      seen_sr = sr_commit; seen_arr = arr_commit; seen_addr = arr_addr; byte_aligned = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 status", 32'(status), 32'h00);
    check("R1 sr_commit", 32'(sr_commit), 0);
    check("R1 arr_commit", 32'(arr_commit), 0);
  endtask

  task automatic t_latch;
    frame(C_WREN, '0, '0, 1'b1, 1'b0);
    check("R2 latch set", 32'(status), 32'h02);
    frame(C_WRDI, '0, '0, 1'b1, 1'b0);
    check("R2 latch cleared", 32'(status), 32'h00);
  endtask

  task automatic t_need_latch;
    frame(C_WRSR, '0, 8'h8C, 1'b1, 1'b0);
    check("R3 no status strobe", 32'(seen_sr), 0);
    check("R3 status kept", 32'(status), 32'h00);
    frame(C_WRITE, 13'h0010, '0, 1'b1, 1'b0);
    check("R3 no array strobe", 32'(seen_arr), 0);
  endtask

  task automatic t_status_write;
    frame(C_WREN, '0, '0, 1'b1, 1'b0);
    frame(C_WRSR, '0, 8'hF5, 1'b1, 1'b0);
    check("R4 strobe", 32'(seen_sr), 1);
    check("R4 fields and latch", 32'(status), 32'h84);
    check("R4 strobe one cycle", 32'(sr_commit), 0);
  endtask

  task automatic t_pin_blocks;
    frame(C_WREN, '0, '0, 1'b1, 1'b0);
    wp_n = 1'b0;
    frame(C_WRSR, '0, 8'h00, 1'b1, 1'b0);
    check("R6 held low blocks", 32'(seen_sr), 0);
    check("R6 status and latch kept", 32'(status), 32'h86);
    wp_n = 1'b1;
    frame(C_WRSR, '0, 8'h00, 1'b1, 1'b1);
    check("R6 pulse aborts", 32'(seen_sr), 0);
    check("R6 status kept after pulse", 32'(status), 32'h86);
    frame(C_WRSR, '0, 8'h08, 1'b1, 1'b0);
    check("R6 pin high allows", 32'(status), 32'h08);
  endtask

  task automatic t_pin_ignored;
    wp_n = 1'b0;
    frame(C_WREN, '0, '0, 1'b1, 1'b0);
    frame(C_WRSR, '0, 8'h0C, 1'b1, 1'b1);
    check("R5 commit with pin low", 32'(seen_sr), 1);
    check("R5 status", 32'(status), 32'h0C);
    wp_n = 1'b1;
  endtask

  task automatic t_busy;
    frame(C_WREN, '0, '0, 1'b1, 1'b0);
    frame(C_WRSR, '0, 8'h84, 1'b1, 1'b0);
    busy = 1'b1;
    wp_n = 1'b0;
    repeat (3) @(negedge clk);
    wp_n = 1'b1;
    @(negedge clk) wp_n = 1'b0;
    @(negedge clk);
    check("R7 committed value holds", 32'(status), 32'h85);
    frame(C_WREN, '0, '0, 1'b1, 1'b0);
    check("R10 enable ignored while busy", 32'(status), 32'h85);
    busy = 1'b0;
    wp_n = 1'b1;
    @(negedge clk);
    check("R10 busy bit clears", 32'(status), 32'h84);
  endtask

  task automatic t_unaligned;
    frame(C_WREN, '0, '0, 1'b0, 1'b0);
    check("R9 unaligned enable dropped", 32'(status), 32'h84);
    frame(C_WREN, '0, '0, 1'b1, 1'b0);
    frame(C_WRSR, '0, 8'h00, 1'b0, 1'b0);
    check("R9 unaligned status write dropped", 32'(seen_sr), 0);
    check("R9 status unchanged", 32'(status), 32'h86);
  endtask

  task automatic arr_try(input string tag, input logic [AW-1:0] a, input logic exp_ok);
    frame(C_WREN, '0, '0, 1'b1, 1'b0);
    frame(C_WRITE, a, '0, 1'b1, 1'b0);
    check(tag, 32'(seen_arr), 32'(exp_ok));
    if (exp_ok) check({tag, " addr"}, 32'(seen_addr), 32'(a));
    check({tag, " latch"}, 32'(status[1]), exp_ok ? 0 : 1);
  endtask

  task automatic set_status(input logic [7:0] v);
    frame(C_WREN, '0, '0, 1'b1, 1'b0);
    frame(C_WRSR, '0, v, 1'b1, 1'b0);
  endtask

  task automatic t_regions;
    arr_try("R8 quarter locked top", 13'h1800, 1'b0);
    arr_try("R8 quarter free below", 13'h17FF, 1'b1);
    set_status(8'h08);
    arr_try("R8 half locked", 13'h1000, 1'b0);
    arr_try("R8 half free below", 13'h0FFF, 1'b1);
    set_status(8'h0C);
    arr_try("R8 all locked", 13'h0000, 1'b0);
    set_status(8'h80);
    arr_try("R8 none locked", 13'h1FFF, 1'b1);
  endtask

  task automatic t_array_pin;
    wp_n = 1'b0;
    arr_try("R12 array write with pin low", 13'h1FFF, 1'b1);
    check("R12 status", 32'(status), 32'h80);
    wp_n = 1'b1;
  endtask

  task automatic two_cmd(input logic [1:0] first, input logic [1:0] second);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) begin cmd_valid = 1'b1; cmd_op = first; end
    @(negedge clk) cmd_valid = 1'b0;
    @(negedge clk) begin cmd_valid = 1'b1; cmd_op = second; end
    @(negedge clk) cmd_valid = 1'b0;
    @(negedge clk) begin cs_n = 1'b1; byte_aligned = 1'b1; end
    @(negedge clk) byte_aligned = 1'b0;
  endtask

  task automatic t_first_wins;
    two_cmd(C_WREN, C_WRDI);
    check("R11 first command enables", 32'(status), 32'h82);
    two_cmd(C_WRDI, C_WREN);
    check("R11 first command disables", 32'(status), 32'h80);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wp_n = 1'b1; busy = 1'b0; cmd_valid = 1'b0;
    cmd_op = '0; cmd_addr = '0; cmd_data = '0; byte_aligned = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch();
    t_need_latch();
    t_status_write();
    t_pin_blocks();
    t_pin_ignored();
    t_busy();
    t_unaligned();
    t_regions();
    t_array_pin();
    t_first_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule